// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block computes a single-error-correcting, double-error-detecting parity code over one flash page while the page's bytes stream through it. Each byte arrives with a valid strobe. A start-of-page pulse clears the accumulated code and any earlier verdict and restarts the byte count. Column parities come from fixed bit groups inside each byte. Line parities come from the bits of the byte's index within the page, and each one is kept together with its complement.

Once the last byte of the page has been accepted, the block presents the finished code and holds it. The caller can then supply the code that was stored alongside the page and pulse a compare strobe. The block XORs the two codes and classifies the difference. If a single data bit flipped, it also reports that bit's byte index and bit index. Because every parity is split into a true half and a complement half, these indices can be read straight off the difference pattern.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset, and in the cycle after a start-of-page pulse that carries no byte, `code_o` is all zero and `page_done_o` and `stat_valid_o` are low.
- R2: The code holds three column pairs. Bit 0 is the XOR of data bits 7, 5, 3, 1 over all bytes and bit 1 is the XOR of bits 6, 4, 2, 0. Bit 2 is the XOR of bits 7, 6, 3, 2 and bit 3 is the XOR of bits 5, 4, 1, 0. Bit 4 is the XOR of bits 7, 6, 5, 4 and bit 5 is the XOR of bits 3, 2, 1, 0.
- R3: For each byte-index bit j, code bit 6+2j accumulates the parity of every byte whose index has bit j set, and code bit 7+2j accumulates the parity of every byte whose index has bit j clear. The first accepted byte has index 0.
- R4: `page_done_o` and the final `code_o` appear in the cycle after the PAGE_BYTES-th byte is accepted. Until the next start-of-page pulse, further bytes are ignored and `page_done_o` stays high.
- R5: A byte presented in the same cycle as the start-of-page pulse is taken as byte 0 of the new page.
- R6: A compare while `page_done_o` is high sets `stat_valid_o` in the next cycle. If the stored code equals the computed code, `stat_o` = 0 (no error).
- R7: `stat_o` = 1 reports a correctable single data-bit error. This applies when every true/complement pair of the difference has exactly one bit set. In that case `err_byte_o` gives the failing byte index and `err_bit_o` gives the failing bit index.
- R8: `stat_o` = 2 reports an error in the stored code itself, which is the case when the difference has exactly one bit set.
- R9: `stat_o` = 3 reports an uncorrectable error, which covers every other non-zero difference.
- R10: A compare strobe while `page_done_o` is low is ignored. A verdict holds until the next compare, start-of-page pulse or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop_i | input | 1 | Start-of-page pulse |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| cmp_i | input | 1 | Compare strobe |
| stored_code_i | input | CODE_W (24) | Code read back from the spare area |
| code_o | output | CODE_W (24) | Computed code |
| page_done_o | output | 1 | Whole page accepted |
| stat_valid_o | output | 1 | Verdict valid |
| stat_o | output | 2 | 0 clean, 1 data bit, 2 code bit, 3 uncorrectable |
| err_byte_o | output | ADDR_W (9) | Failing byte index |
| err_bit_o | output | 3 | Failing bit index |

## Verification
The assertions check three things on every cycle. The code and the done flag hold still once a page is complete. A start-of-page pulse that carries no byte clears the accumulator. A verdict neither appears without a completed page nor changes without a new compare. The parity values, the byte and bit positions and the four-way classification depend on whole-page data, so only the bench scenarios can show them. These scenarios use random pages with injected data flips, single code-bit flips and double flips, a directed single-byte page, and pages that begin with a byte in the start-of-page cycle.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int COL_PAIRS = 3;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_DATA1 = 2'd1,
    ST_CODE1 = 2'd2,
    ST_MULTI = 2'd3
  } ecc_stat_e;
endpackage

// File: rtl/nand_ecc_colpar.sv
module nand_ecc_colpar
  import nand_ecc_pkg::*;
(
  input  logic [7:0]             byte_i,
  output logic [2*COL_PAIRS-1:0] col_o,
  output logic                   par_o
);
  // pair c: true half takes bits whose index has bit c set, complement the rest
  always_comb begin
    col_o = '0;
    for (int c = 0; c < COL_PAIRS; c++) begin
      for (int i = 0; i < 8; i++) begin
        if (((i >> c) & 1) == 1) col_o[2*c]   = col_o[2*c]   ^ byte_i[i];
        else                     col_o[2*c+1] = col_o[2*c+1] ^ byte_i[i];
      end
    end
  end

  assign par_o = ^byte_i;
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int ADDR_W     = $clog2(PAGE_BYTES),
  parameter int CODE_W     = 2*(COL_PAIRS+ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sop_i,
  input  logic              valid_i,
  input  logic [7:0]        byte_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  localparam int                COL_W = 2*COL_PAIRS;
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(PAGE_BYTES-1);

  logic [CODE_W-1:0] acc_q, base_acc, contrib;
  logic [ADDR_W-1:0] idx_q, base_idx;
  logic              done_q, base_done, accept;
  logic [COL_W-1:0]  col;
  logic              par;

  nand_ecc_colpar u_colpar (
    .byte_i (byte_i),
    .col_o  (col),
    .par_o  (par)
  );

  assign base_acc  = sop_i ? '0   : acc_q;
  assign base_idx  = sop_i ? '0   : idx_q;
  assign base_done = sop_i ? 1'b0 : done_q;
  assign accept    = valid_i && !base_done;

  assign contrib[COL_W-1:0] = col;
  for (genvar j = 0; j < ADDR_W; j++) begin : g_line
    assign contrib[COL_W+2*j]   = par &  base_idx[j];
    assign contrib[COL_W+2*j+1] = par & ~base_idx[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (accept) begin
      acc_q  <= base_acc ^ contrib;
      idx_q  <= base_idx + 1'b1;
      done_q <= (base_idx == LAST);
    end else begin
      acc_q  <= base_acc;
      idx_q  <= base_idx;
      done_q <= base_done;
    end
  end

  assign code_o = acc_q;
  assign done_o = done_q;

  p_done_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (done_q && !sop_i) |=> done_q);
  p_ignore_after_done_r4: assert property (@(posedge clk) disable iff (rst)
    (done_q && !sop_i) |=> $stable(acc_q));
  p_sop_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (sop_i && !valid_i) |=> (acc_q == '0 && !done_q));
endmodule

// File: rtl/nand_ecc_decode.sv
module nand_ecc_decode
  import nand_ecc_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int CODE_W = 2*(COL_PAIRS+ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sop_i,
  input  logic              done_i,
  input  logic              cmp_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] stored_i,
  output logic              stat_valid_o,
  output logic [1:0]        stat_o,
  output logic [ADDR_W-1:0] err_byte_o,
  output logic [2:0]        err_bit_o
);
  localparam int PAIRS = CODE_W/2;

  logic [CODE_W-1:0] syn;
  logic [PAIRS-1:0]  pair_odd;
  ecc_stat_e         verdict, stat_q;
  logic [ADDR_W-1:0] byte_pos, byte_q;
  logic [2:0]        bit_pos, bit_q;
  logic              valid_q;

  assign syn = code_i ^ stored_i;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign pair_odd[k] = syn[2*k] ^ syn[2*k+1];
  end
  for (genvar c = 0; c < COL_PAIRS; c++) begin : g_bitpos
    assign bit_pos[c] = syn[2*c];
  end
  for (genvar j = 0; j < ADDR_W; j++) begin : g_bytepos
    assign byte_pos[j] = syn[2*COL_PAIRS+2*j];
  end

  always_comb begin
    if (syn == '0)                  verdict = ST_CLEAN;
    else if (&pair_odd)             verdict = ST_DATA1;
    else if ($countones(syn) == 1)  verdict = ST_CODE1;
    else                            verdict = ST_MULTI;
  end

  always_ff @(posedge clk) begin
    if (rst || sop_i) begin
      valid_q <= 1'b0;
      stat_q  <= ST_CLEAN;
      byte_q  <= '0;
      bit_q   <= '0;
    end else if (cmp_i && done_i) begin
      valid_q <= 1'b1;
      stat_q  <= verdict;
      byte_q  <= (verdict == ST_DATA1) ? byte_pos : '0;
      bit_q   <= (verdict == ST_DATA1) ? bit_pos  : '0;
    end
  end

  assign stat_valid_o = valid_q;
  assign stat_o       = stat_q;
  assign err_byte_o   = byte_q;
  assign err_bit_o    = bit_q;

  p_cmp_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (!done_i && !sop_i) |=> $stable(valid_q));
  p_verdict_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !sop_i && !cmp_i) |=> $stable({stat_q, byte_q, bit_q}));
  p_pos_only_data_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && stat_q != ST_DATA1) |-> (byte_q == '0 && bit_q == '0));
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int ADDR_W     = $clog2(PAGE_BYTES),
  parameter int CODE_W     = 2*(COL_PAIRS+ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sop_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              cmp_i,
  input  logic [CODE_W-1:0] stored_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              page_done_o,
  output logic              stat_valid_o,
  output logic [1:0]        stat_o,
  output logic [ADDR_W-1:0] err_byte_o,
  output logic [2:0]        err_bit_o
);
  logic [CODE_W-1:0] code;
  logic              done;

  nand_ecc_accum #(
    .PAGE_BYTES (PAGE_BYTES),
    .ADDR_W     (ADDR_W),
    .CODE_W     (CODE_W)
  ) u_accum (
    .clk     (clk),
    .rst     (rst),
    .sop_i   (sop_i),
    .valid_i (byte_valid_i),
    .byte_i  (byte_i),
    .code_o  (code),
    .done_o  (done)
  );

  nand_ecc_decode #(
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W)
  ) u_decode (
    .clk          (clk),
    .rst          (rst),
    .sop_i        (sop_i),
    .done_i       (done),
    .cmp_i        (cmp_i),
    .code_i       (code),
    .stored_i     (stored_code_i),
    .stat_valid_o (stat_valid_o),
    .stat_o       (stat_o),
    .err_byte_o   (err_byte_o),
    .err_bit_o    (err_bit_o)
  );

  assign code_o      = code;
  assign page_done_o = done;

  p_verdict_needs_page_r6: assert property (@(posedge clk) disable iff (rst)
    stat_valid_o |-> page_done_o);
endmodule

// File: tb/nand_ecc_engine_tb.sv
module nand_ecc_engine_tb;
  localparam int PB = 512;
  localparam int AW = 9;
  localparam int CW = 24;
  typedef logic [7:0] page_t [PB];

  logic          clk = 0, rst = 1;
  logic          sop = 0, valid = 0, cmp = 0;
  logic [7:0]    din = 0;
  logic [CW-1:0] stored = 0;
  logic [CW-1:0] code;
  logic          done, sval;
  logic [1:0]    stat;
  logic [AW-1:0] ebyte;
  logic [2:0]    ebit;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nand_ecc_engine #(.PAGE_BYTES(PB)) u_dut (
    .clk(clk), .rst(rst), .sop_i(sop), .byte_valid_i(valid), .byte_i(din),
    .cmp_i(cmp), .stored_code_i(stored), .code_o(code), .page_done_o(done),
    .stat_valid_o(sval), .stat_o(stat), .err_byte_o(ebyte), .err_bit_o(ebit)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] ref_code(input page_t d);
    logic [CW-1:0] c = '0;
    for (int b = 0; b < PB; b++) begin
      logic [7:0] x = d[b];
      logic p = ^x;
      c[0] ^= ^(x & 8'hAA); c[1] ^= ^(x & 8'h55);
      c[2] ^= ^(x & 8'hCC); c[3] ^= ^(x & 8'h33);
      c[4] ^= ^(x & 8'hF0); c[5] ^= ^(x & 8'h0F);
      for (int j = 0; j < AW; j++) begin
        if (b[j]) c[6+2*j] ^= p;
        else      c[7+2*j] ^= p;
      end
    end
    return c;
  endfunction

  function automatic logic [1:0] ref_class(input logic [CW-1:0] s);
    bit ok = 1;
    if (s == '0) return 2'd0;
    for (int k = 0; k < CW/2; k++) if (s[2*k] == s[2*k+1]) ok = 0;
    if (ok) return 2'd1;
    if ($countones(s) == 1) return 2'd2;
    return 2'd3;
  endfunction

  // streams a page; first byte optionally rides on the start pulse (R5)
  task automatic send_page(input page_t d, input bit combined, input int gap);
    int start;
    @(negedge clk);
    sop = 1;
    if (combined) begin valid = 1; din = d[0]; start = 1; end
    else begin valid = 0; start = 0; end
    @(negedge clk);
    sop = 0; valid = 0;
    if (!combined) begin
      check("R1 code cleared by start", code, 0);
      check("R1 verdict cleared by start", sval, 0);
      cmp = 1; stored = 24'h123456;
      @(negedge clk);
      cmp = 0;
      check("R10 compare before done ignored", sval, 0);
    end
    for (int b = start; b < PB; b++) begin
      int g = $urandom % gap;
      valid = 0;
      for (int w = 0; w < g; w++) @(negedge clk);
      if (b == PB/2) check("R4 not done mid-page", done, 0);
      valid = 1; din = d[b];
      @(negedge clk);
    end
    valid = 0;
  endtask

  task automatic compare(input logic [CW-1:0] s, input logic [1:0] xs,
                         input int xb, input int xi, input string req);
    cmp = 1; stored = s;
    @(negedge clk);
    cmp = 0;
    check({req, " verdict valid"}, sval, 1);
    check({req, " verdict"}, stat, xs);
    check({req, " byte position"}, ebyte, (xs == 1) ? xb : 0);
    check({req, " bit position"}, ebit, (xs == 1) ? xi : 0);
    repeat (3) @(negedge clk);
    check("R10 verdict holds", {sval, stat}, {1'b1, xs});
  endtask

  initial begin
    page_t pg, bad;
    logic [CW-1:0] good;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset code", code, 0);
    check("R1 reset done", done, 0);
    check("R1 reset verdict", sval, 0);

    // directed: only byte 5 holds 0x01
    for (int b = 0; b < PB; b++) pg[b] = 8'h00;
    pg[5] = 8'h01;
    send_page(pg, 0, 1);
    check("R2 R3 directed single-byte code", code, 24'hAAA66A);
    check("R4 done after last byte", done, 1);
    compare(24'hAAA66A, 2'd0, 0, 0, "R6 clean directed");

    for (int p = 0; p < 16; p++) begin
      int mode = p % 4;
      int b1 = $urandom % PB;
      int i1 = $urandom % 8;
      int b2 = (b1 + 1 + ($urandom % (PB-1))) % PB;
      int i2 = $urandom % 8;
      logic [CW-1:0] s;
      for (int b = 0; b < PB; b++) pg[b] = 8'($urandom);
      bad = pg;
      if (mode == 1) bad[b1][i1] = ~bad[b1][i1];
      if (mode == 3) begin
        bad[b1][i1] = ~bad[b1][i1];
        bad[b2][i2] = ~bad[b2][i2];
      end
      good = ref_code(pg);
      send_page(bad, (p % 3) == 0, (p % 2) ? 3 : 1);
      check((p % 3) == 0 ? "R5 R2 R3 code with combined start" : "R2 R3 page code",
            code, ref_code(bad));
      check("R4 done after last byte", done, 1);
      s = good;
      if (mode == 2) s = good ^ (24'h1 << ($urandom % CW));
      case (mode)
        0: compare(s, 2'd0, 0, 0, "R6 clean page");
        1: compare(s, 2'd1, b1, i1, "R7 single data bit");
        2: compare(s, 2'd2, 0, 0, "R8 stored code bit");
        default: compare(s, ref_class(s ^ ref_code(bad)), 0, 0, "R9 double flip");
      endcase
      if (mode == 3) check("R9 double flip is uncorrectable", ref_class(s ^ ref_code(bad)), 3);
      // extra bytes after completion are ignored
      for (int e = 0; e < 4; e++) begin
        valid = 1; din = 8'($urandom);
        @(negedge clk);
      end
      valid = 0;
      check("R4 extra bytes ignored", code, ref_code(bad));
      check("R4 done held", done, 1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule